// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming port of one eight-line slice of a priority interrupt controller. Software reaches it through two addresses. Writes to the low address carry either the first word of an initialization sequence or one of two run-time command words. Writes to the high address carry the later initialization words or, once initialization is over, a new interrupt mask. Reads return the request, in-service or mask register, or the result of a poll.

The decoder holds the mode bits and the mask. It turns each command into one-cycle strobes for the request and in-service registers and for the rotating priority offset. Those registers live beside it, in the rest of the slice. A priority resolver, which is outside this block, supplies two results: the highest-priority in-service line, used by the non-specific end-of-interrupt commands, and the winning request line, used by poll reads. Every output comes from a register. Read data is combinational and depends on the address and the current state.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the mask, vector base and all mode bits are 0, no strobe is active, and no init sequence is in progress.
- R2: A low-address write with bit 4 = 1 and bit 3 = 0 starts a new init. In the next cycle `slice_rst` pulses, the mask and the run-time mode bits are 0, `single_mode` = bit 1, `four_word` = bit 0, and `init_busy` = 1.
- R3: A low-address write with bit 4 = 1 and bit 3 = 1 asks for level-triggered mode. It is refused: `level_err` is set, and the mask and mode bits are not changed.
- R4: After an init start, the next high-address write sets `vec_base` to the written value AND 0xF8. After that word the sequence is: in single mode, go to the mode word if `four_word` is set and otherwise finish; in cascade mode, skip one cascade word and then go to the mode word if `four_word` is set, otherwise finish.
- R5: The mode word sets `nested_mode` from bit 4 and `auto_eoi` from bit 1, and ends the sequence.
- R6: A high-address write while no init is in progress loads the mask. A high-address read returns the mask.
- R7: A low-address write with bit 4 = 0 and bit 3 = 1 sets `read_sel` from bit 0 and `poll` from bit 2. It sets `special_mask` from bit 5 only when bit 6 = 1.
- R8: Any other low-address write is a command in bits 7:5. Command 1 clears the in-service bit of the resolver's in-service line, if that line is valid. Command 5 does the same and also loads the priority offset with (line + 1) mod 8.
- R9: Command 3 clears the in-service bit named by bits 2:0. Command 7 does the same and also loads the offset with (bits 2:0 + 1) mod 8. Command 6 only loads the offset with (bits 2:0 + 1) mod 8.
- R10: Commands 0 and 4 set `rot_aeoi` to bit 7 of the write, so command 4 sets it and command 0 clears it.
- R11: A low-address read returns the in-service input when `read_sel` = 1 and the request input otherwise.
- R12: A low-address read while `poll` = 1 returns {winner valid, 0000, winner line} and clears `poll`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 1 | Register address, 0 = low, 1 = high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irr_in | input | 8 | Request register of the slice |
| isr_in | input | 8 | In-service register of the slice |
| hp_isr_valid | input | 1 | Resolver found an in-service line |
| hp_isr_line | input | 3 | Highest-priority in-service line |
| poll_valid | input | 1 | Resolver found an unmasked request that wins |
| poll_line | input | 3 | Winning request line |
| vec_base | output | 8 | Vector base, low three bits zero |
| single_mode | output | 1 | Slice runs without a cascade partner |
| four_word | output | 1 | Init sequence includes a mode word |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate priority on automatic end of interrupt |
| imr | output | 8 | Interrupt mask |
| read_sel | output | 1 | Low-address read selects in-service |
| special_mask | output | 1 | Special mask mode |
| poll | output | 1 | Poll read pending |
| level_err | output | 1 | Level-triggered init refused |
| init_busy | output | 1 | Init sequence in progress |
| slice_rst | output | 1 | One-cycle reset pulse for the slice |
| isr_clr | output | 8 | One-cycle in-service clear strobes |
| prio_set | output | 1 | One-cycle priority offset load |
| prio_val | output | 3 | New priority offset |

## Verification
The hardest case to reach is the cascade init path. The word that follows the vector base is taken in and then dropped, so it must not reach the mask. The stimulus writes a distinctive value at exactly that step, then reads the mask. A later high-address write shows whether the sequence ended at the right word. The poll read is the other delicate case, because its side effect shows up only on the next read. The bench therefore reads twice: first with the resolver presenting a winner, then again to see the normal register come back.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_step_e;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_cmd_pkg::*;
(
    input  init_step_e step,
    input  logic       single,
    input  logic       four,
    input  logic       odd_wr,
    output init_step_e step_nxt,
    output logic       ld_base,
    output logic       ld_mode,
    output logic       ld_mask
);
    always_comb begin
        step_nxt = step;
        ld_base  = 1'b0;
        ld_mode  = 1'b0;
        ld_mask  = 1'b0;
        case (step)
            ST_IDLE: ld_mask = odd_wr;
            ST_BASE: if (odd_wr) begin
                ld_base  = 1'b1;
                step_nxt = single ? (four ? ST_MODE : ST_IDLE) : ST_CASC;
            end
            ST_CASC: if (odd_wr) begin
                step_nxt = four ? ST_MODE : ST_IDLE;
            end
            ST_MODE: if (odd_wr) begin
                ld_mode  = 1'b1;
                step_nxt = ST_IDLE;
            end
            default: step_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/irq_eoi_exec.sv
module irq_eoi_exec #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic [2:0]       cmd,
    input  logic [LW-1:0]    lvl,
    input  logic             hp_valid,
    input  logic [LW-1:0]    hp_line,
    output logic [LINES-1:0] clr,
    output logic             pset,
    output logic [LW-1:0]    pval,
    output logic             rot_we,
    output logic             rot_val
);
    always_comb begin
        clr     = '0;
        pset    = 1'b0;
        pval    = '0;
        rot_we  = 1'b0;
        rot_val = cmd[2];
        case (cmd)
            3'd0, 3'd4: rot_we = 1'b1;
            3'd1, 3'd5: if (hp_valid) begin
                clr[hp_line] = 1'b1;
                if (cmd[2]) begin
                    pset = 1'b1;
                    pval = hp_line + LW'(1);
                end
            end
            3'd3, 3'd7: begin
                clr[lvl] = 1'b1;
                if (cmd[2]) begin
                    pset = 1'b1;
                    pval = lvl + LW'(1);
                end
            end
            3'd6: begin
                pset = 1'b1;
                pval = lvl + LW'(1);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             addr,
    input  logic             sel_isr,
    input  logic             poll_pend,
    input  logic             win_valid,
    input  logic [LW-1:0]    win_line,
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] isr,
    input  logic [LINES-1:0] mask,
    output logic [LINES-1:0] dout
);
    always_comb begin
        if (addr)
            dout = mask;
        else if (poll_pend)
            dout = {win_valid, {(LINES-1-LW){1'b0}}, win_line};
        else if (sel_isr)
            dout = isr;
        else
            dout = irr;
    end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
    import irq_cmd_pkg::*;
#(
    parameter int LINES = 8,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic [LINES-1:0] irr_in,
    input  logic [LINES-1:0] isr_in,
    input  logic             hp_isr_valid,
    input  logic [LW-1:0]    hp_isr_line,
    input  logic             poll_valid,
    input  logic [LW-1:0]    poll_line,
    output logic [LINES-1:0] vec_base,
    output logic             single_mode,
    output logic             four_word,
    output logic             nested_mode,
    output logic             auto_eoi,
    output logic             rot_aeoi,
    output logic [LINES-1:0] imr,
    output logic             read_sel,
    output logic             special_mask,
    output logic             poll,
    output logic             level_err,
    output logic             init_busy,
    output logic             slice_rst,
    output logic [LINES-1:0] isr_clr,
    output logic             prio_set,
    output logic [LW-1:0]    prio_val
);
    localparam logic [LINES-1:0] BASE_MASK = {{(LINES-LW){1'b1}}, {LW{1'b0}}};

    typedef struct packed {
        init_step_e       step;
        logic [LINES-1:0] vbase;
        logic             single;
        logic             four;
        logic             sfnm;
        logic             aeoi;
        logic             rot;
        logic [LINES-1:0] mask;
        logic             rsel;
        logic             poll;
        logic             smask;
        logic             lerr;
        logic [LINES-1:0] clr;
        logic             pset;
        logic [LW-1:0]    pval;
        logic             srst;
    } dec_state_t;

    dec_state_t st_q, st_d;

    init_step_e       seq_nxt;
    logic             ld_base, ld_mode, ld_mask;
    logic [LINES-1:0] eoi_clr;
    logic             eoi_pset, rot_we, rot_val;
    logic [LW-1:0]    eoi_pval;

    irq_init_seq u_seq (
        .step    (st_q.step),
        .single  (st_q.single),
        .four    (st_q.four),
        .odd_wr  (wr_en && addr),
        .step_nxt(seq_nxt),
        .ld_base (ld_base),
        .ld_mode (ld_mode),
        .ld_mask (ld_mask)
    );

    irq_eoi_exec #(.LINES(LINES)) u_eoi (
        .cmd     (wdata[LINES-1:LINES-3]),
        .lvl     (wdata[LW-1:0]),
        .hp_valid(hp_isr_valid),
        .hp_line (hp_isr_line),
        .clr     (eoi_clr),
        .pset    (eoi_pset),
        .pval    (eoi_pval),
        .rot_we  (rot_we),
        .rot_val (rot_val)
    );

    irq_rd_mux #(.LINES(LINES)) u_rd (
        .addr     (addr),
        .sel_isr  (st_q.rsel),
        .poll_pend(st_q.poll),
        .win_valid(poll_valid),
        .win_line (poll_line),
        .irr      (irr_in),
        .isr      (isr_in),
        .mask     (st_q.mask),
        .dout     (rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.clr  = '0;
        st_d.pset = 1'b0;
        st_d.srst = 1'b0;
        if (wr_en && !addr) begin
            if (wdata[4]) begin
                if (wdata[3]) begin
                    st_d.lerr = 1'b1;
                end else begin
                    st_d.step   = ST_BASE;
                    st_d.single = wdata[1];
                    st_d.four   = wdata[0];
                    st_d.sfnm   = 1'b0;
                    st_d.aeoi   = 1'b0;
                    st_d.rot    = 1'b0;
                    st_d.mask   = '0;
                    st_d.rsel   = 1'b0;
                    st_d.poll   = 1'b0;
                    st_d.smask  = 1'b0;
                    st_d.lerr   = 1'b0;
                    st_d.srst   = 1'b1;
                end
            end else if (wdata[3]) begin
                st_d.rsel = wdata[0];
                st_d.poll = wdata[2];
                if (wdata[6]) st_d.smask = wdata[5];
            end else begin
                st_d.clr  = eoi_clr;
                st_d.pset = eoi_pset;
                if (eoi_pset) st_d.pval = eoi_pval;
                if (rot_we)   st_d.rot  = rot_val;
            end
        end else if (wr_en && addr) begin
            st_d.step = seq_nxt;
            if (ld_base) st_d.vbase = wdata & BASE_MASK;
            if (ld_mask) st_d.mask  = wdata;
            if (ld_mode) begin
                st_d.sfnm = wdata[4];
                st_d.aeoi = wdata[1];
            end
        end
        if (rd_en && !addr && st_q.poll) st_d.poll = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_base     = st_q.vbase;
    assign single_mode  = st_q.single;
    assign four_word    = st_q.four;
    assign nested_mode  = st_q.sfnm;
    assign auto_eoi     = st_q.aeoi;
    assign rot_aeoi     = st_q.rot;
    assign imr          = st_q.mask;
    assign read_sel     = st_q.rsel;
    assign special_mask = st_q.smask;
    assign poll         = st_q.poll;
    assign level_err    = st_q.lerr;
    assign init_busy    = (st_q.step != ST_IDLE);
    assign slice_rst    = st_q.srst;
    assign isr_clr      = st_q.clr;
    assign prio_set     = st_q.pset;
    assign prio_val     = st_q.pval;

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4] && !wdata[3]) |=> (slice_rst && imr == '0 && init_busy));

    a_r3_level_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4] && wdata[3]) |=> (level_err && $stable(imr) && !slice_rst));

    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !init_busy) |=> (imr == $past(wdata)));

    a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr_clr));

    a_r12_poll_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll && !wr_en) |=> !poll);
endmodule

// File: tb/irq_cmd_decoder_tb.sv
`timescale 1ns/1ps
module irq_cmd_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irr_in = 8'h5A, isr_in = 8'hC3;
    logic       hp_isr_valid = 1'b0, poll_valid = 1'b0;
    logic [2:0] hp_isr_line = '0, poll_line = '0;
    logic [7:0] vec_base, imr, isr_clr;
    logic       single_mode, four_word, nested_mode, auto_eoi, rot_aeoi;
    logic       read_sel, special_mask, poll, level_err, init_busy, slice_rst, prio_set;
    logic [2:0] prio_val;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
        .hp_isr_valid(hp_isr_valid), .hp_isr_line(hp_isr_line),
        .poll_valid(poll_valid), .poll_line(poll_line),
        .vec_base(vec_base), .single_mode(single_mode), .four_word(four_word),
        .nested_mode(nested_mode), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
        .imr(imr), .read_sel(read_sel), .special_mask(special_mask), .poll(poll),
        .level_err(level_err), .init_busy(init_busy), .slice_rst(slice_rst),
        .isr_clr(isr_clr), .prio_set(prio_set), .prio_val(prio_val)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 imr", imr, 0);
        check("R1 vec_base", vec_base, 0);
        check("R1 modes", {single_mode, four_word, nested_mode, auto_eoi, rot_aeoi}, 0);
        check("R1 busy/strobes", {init_busy, slice_rst, prio_set, isr_clr}, 0);
        rd(1'b0, v);
        check("R11 reset read irr", v, 8'h5A);
    endtask

    task automatic t_init_single_four();
        logic [7:0] v;
        wr(1'b0, 8'h13);
        check("R2 slice_rst", slice_rst, 1);
        check("R2 single/four/busy", {single_mode, four_word, init_busy}, 3'b111);
        wr(1'b1, 8'h47);
        check("R4 vec_base and", vec_base, 8'h40);
        check("R4 still busy", init_busy, 1);
        wr(1'b1, 8'h12);
        check("R5 nested/aeoi", {nested_mode, auto_eoi}, 2'b11);
        check("R5 done", init_busy, 0);
        wr(1'b1, 8'hA5);
        check("R6 mask load", imr, 8'hA5);
        rd(1'b1, v);
        check("R6 mask read", v, 8'hA5);
    endtask

    task automatic t_init_single_three();
        wr(1'b0, 8'h12);
        check("R2 modes cleared", {auto_eoi, nested_mode, imr}, 0);
        check("R2 single no four", {single_mode, four_word}, 2'b10);
        wr(1'b1, 8'h27);
        check("R4 base", vec_base, 8'h20);
        check("R4 single ends", init_busy, 0);
        wr(1'b1, 8'h3C);
        check("R6 mask after short init", imr, 8'h3C);
    endtask

    task automatic t_init_cascade();
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h88);
        check("R4 base cascade", vec_base, 8'h88);
        wr(1'b1, 8'h04);
        check("R4 cascade word not mask", imr, 0);
        check("R4 busy at mode word", init_busy, 1);
        wr(1'b1, 8'h02);
        check("R5 aeoi only", {nested_mode, auto_eoi}, 2'b01);
        wr(1'b1, 8'h77);
        check("R6 mask after cascade", imr, 8'h77);
    endtask

    task automatic t_level();
        wr(1'b0, 8'h18);
        check("R3 level_err", level_err, 1);
        check("R3 mask kept", imr, 8'h77);
        check("R3 no reset, idle", {slice_rst, init_busy, auto_eoi}, 3'b001);
    endtask

    task automatic t_ocw3();
        logic [7:0] v;
        wr(1'b0, 8'h6B);
        check("R7 rsel/smask", {read_sel, special_mask, poll}, 3'b110);
        rd(1'b0, v);
        check("R11 read isr", v, 8'hC3);
        wr(1'b0, 8'h2A);
        check("R7 smask held without bit6", {read_sel, special_mask}, 2'b01);
        rd(1'b0, v);
        check("R11 read irr", v, 8'h5A);
        wr(1'b0, 8'h0C);
        check("R7 poll set", poll, 1);
        poll_valid = 1'b1; poll_line = 3'd5;
        rd(1'b0, v);
        check("R12 poll result", v, 8'h85);
        check("R12 poll cleared", poll, 0);
        rd(1'b0, v);
        check("R12 normal read after poll", v, 8'h5A);
        poll_valid = 1'b0;
    endtask

    task automatic t_nonspecific();
        hp_isr_valid = 1'b1; hp_isr_line = 3'd6;
        wr(1'b0, 8'h20);
        check("R8 cmd1 clear", isr_clr, 8'h40);
        check("R8 cmd1 no prio", prio_set, 0);
        wr(1'b0, 8'hA0);
        check("R8 cmd5 clear", isr_clr, 8'h40);
        check("R8 cmd5 prio", {prio_set, prio_val}, {1'b1, 3'd7});
        hp_isr_line = 3'd7;
        wr(1'b0, 8'hA0);
        check("R8 cmd5 wrap", {prio_set, prio_val}, {1'b1, 3'd0});
        hp_isr_valid = 1'b0;
        wr(1'b0, 8'h20);
        check("R8 none in service", {prio_set, isr_clr}, 0);
        @(negedge clk);
        check("R8 strobe one cycle", isr_clr, 0);
    endtask

    task automatic t_specific();
        wr(1'b0, 8'h62);
        check("R9 cmd3 clear", isr_clr, 8'h04);
        check("R9 cmd3 no prio", prio_set, 0);
        wr(1'b0, 8'hE3);
        check("R9 cmd7", {isr_clr, prio_set, prio_val}, {8'h08, 1'b1, 3'd4});
        wr(1'b0, 8'hC7);
        check("R9 cmd6", {isr_clr, prio_set, prio_val}, {8'h00, 1'b1, 3'd0});
    endtask

    task automatic t_rotate();
        wr(1'b0, 8'h80);
        check("R10 cmd4 sets", rot_aeoi, 1);
        wr(1'b0, 8'h40);
        check("R10 cmd2 no effect", rot_aeoi, 1);
        wr(1'b0, 8'h00);
        check("R10 cmd0 clears", rot_aeoi, 0);
        wr(1'b0, 8'h80);
        wr(1'b0, 8'h10);
        check("R2 init clears rot/rsel/smask/err", {rot_aeoi, read_sel, special_mask, level_err}, 0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_single_four();
        t_init_single_three();
        t_init_cascade();
        t_level();
        t_ocw3();
        t_nonspecific();
        t_specific();
        t_rotate();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule